// File: doc/BRIEF.md
# Single-to-Half Precision Float Converter

This block turns IEEE-754 binary32 operands into binary16 results using round-to-nearest, ties-to-even. Each operand comes with a valid strobe. The result appears with its own valid strobe exactly one clock later, and a new operand can be accepted on every cycle. It suits storage paths that compute in single precision and store values at half width, such as lookup tables or scratch buffers.

Inside, the operand is classified, its significand is aligned onto the half-precision grid, and the bits shifted out are kept as a guard bit and a sticky bit. The rounding increment is added to the packed exponent-and-fraction word. Any carry out of the fraction therefore moves into the exponent: a subnormal can become normal, and the top normal can become infinity. Exponent and fraction widths are parameters, and elaboration checks that they are consistent.

Top module: `f32_to_f16_cvt`

## Requirements
- R1: `out_valid` is low after synchronous reset, and otherwise equals the `in_valid` of the previous cycle. `out_data` belongs to the operand presented on that earlier cycle.
- R2: For every result that is not NaN, output bit 15 equals input bit 31.
- R3: An input whose exponent bits 30:23 are all ones and whose fraction bits 22:0 are zero gives a signed infinity: magnitude 0x7C00.
- R4: An input whose exponent bits are all ones and whose fraction is nonzero gives exactly 0x7FFF, whatever its sign and payload.
- R5: An input whose biased exponent (bits 30:23) is below 102 gives signed zero. This covers zeros and single-precision subnormals.
- R6: An input whose unbiased exponent is above 15 gives signed infinity.
- R7: Unbiased exponents from -14 to 15 give a normal result. It takes the top 11 significand bits, including the hidden bit, with output exponent field equal to the unbiased exponent plus 15, and is then rounded.
- R8: Unbiased exponents from -25 to -15 give a subnormal result. The 24-bit significand is shifted right by (-1 minus the unbiased exponent), the exponent field is zero, and the result is rounded rather than truncated.
- R9: The 15-bit magnitude is incremented when the discarded bits exceed one half of the last place, or equal exactly one half while the last kept bit is 1.
- R10: A rounding carry moves into the exponent. 65520 gives 0x7C00, and a value just below 2^-14 can round to 0x0400.
- R11: Exactly 2^-25 gives signed zero. A value slightly above 2^-25 gives magnitude 0x0001.
- R12: Operands presented on consecutive cycles each produce their own correct result, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_data | input | 32 | binary32 operand |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | 16 | binary16 result |

## Verification
The assertions assume that `in_data` is stable and fully defined whenever `in_valid` is high. They also assume that `rst` is held for at least one edge before the first operand. The stimulus drives operands only on the falling edge, from known constants or from `$urandom`, so no undefined bits reach the classifier. It applies reset for several cycles before any traffic and keeps `in_valid` low during reset. Both the random sweep and the exponent-focused sweep generate every operand from a defined 32-bit word, so the result checks never see an unknown value.

// File: rtl/f2h_pkg.sv
package f2h_pkg;

   typedef enum logic [2:0] {
      CLS_ZERO = 3'd0,
      CLS_SUB  = 3'd1,
      CLS_NORM = 3'd2,
      CLS_OVF  = 3'd3,
      CLS_INF  = 3'd4,
      CLS_NAN  = 3'd5
   } f2h_class_e;

   function automatic int f2h_bias(input int exp_w);
      return (1 << (exp_w - 1)) - 1;
   endfunction

endpackage

// File: rtl/f2h_classify.sv
module f2h_classify
   import f2h_pkg::*;
#(
   parameter int EXP_IN   = 8,
   parameter int FRAC_IN  = 23,
   parameter int EXP_OUT  = 5,
   parameter int FRAC_OUT = 10,
   parameter int SH_W     = $clog2(FRAC_IN + 2)
) (
   input  logic [EXP_IN-1:0]  exp_field,
   input  logic               frac_nz,
   output f2h_class_e         cls,
   output logic [SH_W-1:0]    shamt,
   output logic [EXP_OUT-1:0] exp_add
);
   localparam int IN_BIAS  = f2h_bias(EXP_IN);
   localparam int OUT_BIAS = f2h_bias(EXP_OUT);
   localparam int NORM_MIN = 1 - OUT_BIAS;
   localparam int SUB_MIN  = NORM_MIN - (FRAC_OUT + 1);
   localparam int BASE_SH  = FRAC_IN - FRAC_OUT;
   localparam int EXP_MAX  = (1 << EXP_IN) - 1;

   int unb;
   int sh;
   int ea;

   always_comb begin
      unb = int'(exp_field) - IN_BIAS;
      sh  = BASE_SH;
      ea  = 0;
      if (int'(exp_field) == EXP_MAX) begin
         cls = frac_nz ? CLS_NAN : CLS_INF;
      end else if (unb < SUB_MIN) begin
         cls = CLS_ZERO;
      end else if (unb > OUT_BIAS) begin
         cls = CLS_OVF;
      end else if (unb < NORM_MIN) begin
         cls = CLS_SUB;
         sh  = BASE_SH + (NORM_MIN - unb);
      end else begin
         cls = CLS_NORM;
         ea  = unb + OUT_BIAS - 1;
      end
      shamt   = sh[SH_W-1:0];
      exp_add = ea[EXP_OUT-1:0];
   end

   // R8: the subnormal shift never exceeds the significand width
   always_comb begin
      assert_shift_range_R8: assert (int'(shamt) <= FRAC_IN + 1);
   end

endmodule

// File: rtl/f2h_align.sv
module f2h_align #(
   parameter int SIG_W  = 24,
   parameter int KEEP_W = 11,
   parameter int SH_W   = $clog2(SIG_W + 1)
) (
   input  logic [SIG_W-1:0]  sig,
   input  logic [SH_W-1:0]   shamt,
   output logic [KEEP_W-1:0] kept,
   output logic              guard,
   output logic              sticky
);
   localparam int WIDE = 2 * SIG_W;

   logic [WIDE-1:0] stage [SH_W+1];

   assign stage[0] = {sig, {SIG_W{1'b0}}};

   for (genvar k = 0; k < SH_W; k++) begin : g_shift
      assign stage[k+1] = shamt[k] ? (stage[k] >> (1 << k)) : stage[k];
   end

   logic [SIG_W-KEEP_W-1:0] kept_hi;

   assign kept_hi = stage[SH_W][WIDE-1:SIG_W+KEEP_W];
   assign kept    = stage[SH_W][SIG_W+KEEP_W-1:SIG_W];
   assign guard   = stage[SH_W][SIG_W-1];
   assign sticky  = |stage[SH_W][SIG_W-2:0];

   // R7: the aligned result always fits in the kept field
   always_comb begin
      assert_align_fit_R7: assert (kept_hi == '0);
   end

endmodule

// File: rtl/f2h_round.sv
module f2h_round #(
   parameter int EXP_OUT  = 5,
   parameter int FRAC_OUT = 10
) (
   input  logic [FRAC_OUT:0]           kept,
   input  logic [EXP_OUT-1:0]          exp_add,
   input  logic                        guard,
   input  logic                        sticky,
   output logic [EXP_OUT+FRAC_OUT-1:0] mag
);
   localparam int MAG_W = EXP_OUT + FRAC_OUT;

   logic [MAG_W-1:0] base;
   logic             bump;

   assign base = {exp_add, {FRAC_OUT{1'b0}}} + MAG_W'(kept);
   assign bump = guard & (sticky | base[0]);
   assign mag  = base + MAG_W'(bump);

   // R10: an increment never wraps the magnitude past the infinity code
   always_comb begin
      assert_no_wrap_R10: assert (base != {MAG_W{1'b1}});
   end

endmodule

// File: rtl/f32_to_f16_cvt.sv
module f32_to_f16_cvt
   import f2h_pkg::*;
#(
   parameter int IN_W     = 32,
   parameter int EXP_IN   = 8,
   parameter int FRAC_IN  = 23,
   parameter int OUT_W    = 16,
   parameter int EXP_OUT  = 5,
   parameter int FRAC_OUT = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [IN_W-1:0]  in_data,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_data
);
   localparam int SIG_W    = FRAC_IN + 1;
   localparam int KEEP_W   = FRAC_OUT + 1;
   localparam int SH_W     = $clog2(SIG_W + 1);
   localparam int MAG_W    = EXP_OUT + FRAC_OUT;
   localparam int IN_BIAS  = f2h_bias(EXP_IN);
   localparam int OUT_BIAS = f2h_bias(EXP_OUT);
   localparam int ZERO_EXP = IN_BIAS + (1 - OUT_BIAS) - (FRAC_OUT + 1);
   localparam logic [MAG_W-1:0] INF_MAG  = {{EXP_OUT{1'b1}}, {FRAC_OUT{1'b0}}};
   localparam logic [OUT_W-1:0] CANON_NAN = {1'b0, {(OUT_W-1){1'b1}}};

   if (IN_W != 1 + EXP_IN + FRAC_IN) begin : g_bad_in
      $error("input width does not match exponent and fraction widths");
   end
   if (OUT_W != 1 + EXP_OUT + FRAC_OUT) begin : g_bad_out
      $error("output width does not match exponent and fraction widths");
   end
   if (EXP_OUT >= EXP_IN || FRAC_OUT >= FRAC_IN) begin : g_bad_narrow
      $error("output format must be narrower than input format");
   end

   logic                sign;
   logic [EXP_IN-1:0]   exp_f;
   logic [FRAC_IN-1:0]  frac_f;
   f2h_class_e          cls;
   logic [SH_W-1:0]     shamt;
   logic [EXP_OUT-1:0]  exp_add;
   logic [KEEP_W-1:0]   kept;
   logic                guard;
   logic                sticky;
   logic [MAG_W-1:0]    mag;
   logic [OUT_W-1:0]    result;

   assign sign   = in_data[IN_W-1];
   assign exp_f  = in_data[IN_W-2:FRAC_IN];
   assign frac_f = in_data[FRAC_IN-1:0];

   f2h_classify #(
      .EXP_IN(EXP_IN), .FRAC_IN(FRAC_IN),
      .EXP_OUT(EXP_OUT), .FRAC_OUT(FRAC_OUT), .SH_W(SH_W)
   ) u_cls (
      .exp_field(exp_f),
      .frac_nz  (|frac_f),
      .cls      (cls),
      .shamt    (shamt),
      .exp_add  (exp_add)
   );

   f2h_align #(.SIG_W(SIG_W), .KEEP_W(KEEP_W), .SH_W(SH_W)) u_aln (
      .sig   ({1'b1, frac_f}),
      .shamt (shamt),
      .kept  (kept),
      .guard (guard),
      .sticky(sticky)
   );

   f2h_round #(.EXP_OUT(EXP_OUT), .FRAC_OUT(FRAC_OUT)) u_rnd (
      .kept   (kept),
      .exp_add(exp_add),
      .guard  (guard),
      .sticky (sticky),
      .mag    (mag)
   );

   always_comb begin
      unique case (cls)
         CLS_ZERO:          result = {sign, {MAG_W{1'b0}}};
         CLS_SUB, CLS_NORM: result = {sign, mag};
         CLS_OVF, CLS_INF:  result = {sign, INF_MAG};
         default:           result = CANON_NAN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= result;
      end
   end

   logic in_nan, in_inf, in_tiny;
   assign in_nan  = (&exp_f) & (|frac_f);
   assign in_inf  = (&exp_f) & ~(|frac_f);
   assign in_tiny = int'(exp_f) < ZERO_EXP;

   assert_valid_follow_R1: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> out_valid == $past(in_valid));

   assert_sign_copy_R2: assert property (@(posedge clk) disable iff (rst)
      out_valid && !$past(rst) && !$past(in_nan) |-> out_data[OUT_W-1] == $past(sign));

   assert_inf_in_R3: assert property (@(posedge clk) disable iff (rst)
      out_valid && !$past(rst) && $past(in_inf) |-> out_data[MAG_W-1:0] == INF_MAG);

   assert_nan_canon_R4: assert property (@(posedge clk) disable iff (rst)
      out_valid && !$past(rst) && $past(in_nan) |-> out_data == CANON_NAN);

   assert_tiny_zero_R5: assert property (@(posedge clk) disable iff (rst)
      out_valid && !$past(rst) && $past(in_tiny) |-> out_data[MAG_W-1:0] == '0);

endmodule

// File: tb/sim_f32_to_f16_cvt.sv
module sim_f32_to_f16_cvt;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        out_valid;
   logic [15:0] out_data;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   bit          pend = 1'b0;
   bit          pend_v;
   logic [15:0] pend_d;
   logic [31:0] pend_in;
   string       pend_tag;

   always #2ns clk = ~clk;

   f32_to_f16_cvt u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data)
   );

   function automatic logic [15:0] model(input logic [31:0] b);
      int          e  = int'(b[30:23]);
      int          fr = int'(b[22:0]);
      logic [15:0] s  = {b[31], 15'd0};
      real         x, q, n, d;
      int          eh;
      longint      f, code;
      if (e == 255) return (fr != 0) ? 16'h7FFF : (s | 16'h7C00);
      if (e < 102) return s;
      x = (8388608.0 + real'(fr)) * (2.0 ** (e - 150));
      if (x >= 65520.0) return s | 16'h7C00;
      eh = -14;
      while (x >= 2.0 ** (eh + 1)) eh++;
      q = 2.0 ** (eh - 10);
      n = x / q;
      f = longint'($floor(n));
      d = n - real'(f);
      if (d > 0.5 || (d == 0.5 && f[0])) f++;
      if (x < 2.0 ** (-14)) code = f;
      else code = longint'(eh + 14) * 1024 + f;
      if (code >= 64'h7C00) code = 64'h7C00;
      return s | 16'(code);
   endfunction

   task automatic settle();
      if (pend) begin
         checks++;
         if (out_valid !== pend_v || (pend_v && out_data !== pend_d)) begin
            errors++;
            $display("FAIL %s in=%h actual v=%b d=%h expected v=%b d=%h",
                     pend_tag, pend_in, out_valid, out_data, pend_v, pend_d);
         end
      end
      pend = 1'b0;
   endtask

   task automatic apply(input bit v, input logic [31:0] d, input string tag);
      @(negedge clk);
      settle();
      in_valid = v;
      in_data  = d;
      pend     = 1'b1;
      pend_v   = v;
      pend_d   = model(d);
      pend_in  = d;
      pend_tag = tag;
   endtask

   initial begin
      #(4ns * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset out_valid actual=%b expected=0", out_valid);
      end

      apply(1, 32'h0000_0000, "R5 +0");
      apply(1, 32'h8000_0000, "R2 -0");
      apply(1, 32'h7F80_0000, "R3 +inf");
      apply(1, 32'hFF80_0000, "R3 -inf");
      apply(1, 32'h7FC0_0000, "R4 qnan");
      apply(1, 32'hFF80_0001, "R4 snan");
      apply(1, 32'h0000_0001, "R5 f32 subnormal");
      apply(1, 32'h32FF_FFFF, "R5 below threshold");
      apply(1, 32'h477F_E000, "R7 65504");
      apply(1, 32'h477F_F000, "R10 65520");
      apply(1, 32'h477F_EFFF, "R9 just below 65520");
      apply(1, 32'h5015_02F9, "R6 large");
      apply(1, 32'hC780_0000, "R6 -65536");
      apply(1, 32'h3880_0000, "R7 2^-14");
      apply(1, 32'h3F80_0000, "R7 one");
      apply(1, 32'h3380_0000, "R8 2^-24");
      apply(1, 32'h3300_0000, "R11 2^-25");
      apply(1, 32'h3300_0001, "R11 above 2^-25");
      apply(1, 32'h3F80_3000, "R9 tie odd");
      apply(1, 32'h3F80_1000, "R9 tie even");
      apply(1, 32'h33C0_0000, "R9 subnormal tie odd");
      apply(1, 32'h387F_F000, "R10 sub to normal");
      apply(1, 32'hB87F_E000, "R8 neg subnormal");
      apply(0, 32'h3F80_0000, "R1 idle");

      for (int i = 0; i < 20000; i++) begin
         apply(1, $urandom, "R12 random");
      end
      for (int i = 0; i < 20000; i++) begin
         logic [31:0] w = $urandom;
         w[30:23] = 8'(100 + ($urandom % 45));
         apply((i % 7) != 3, w, "R8 exponent sweep");
      end

      @(negedge clk);
      settle();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule